// File: doc/BRIEF.md
# Seconds Alarm Timer

This peripheral keeps an unsigned seconds count as wide as its data bus and raises an alarm when that count reaches a programmed value. A free-running prescaler divides the core clock down to one update pulse per second (`TICK_DIV` clocks). On each update pulse, three things happen in a fixed order. A pending load value replaces the count. Otherwise, while counting is switched on, the count steps by one, or it returns to zero when the wrap option is on and the alarm value has just been hit.

Software reaches the block through eight word-addressed registers, using a read strobe and a write strobe. Read data appears one clock after the read strobe. An alarm hit sets a sticky raw flag. The interrupt line is that flag gated by an enable bit and a mask bit. Software acknowledges the alarm by reading a dedicated acknowledge register, and the data returned by that read is zero.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset, the count, alarm, load and control registers read zero, both status registers read zero, and `irq` is low.
- R2: The prescaler issues one update pulse every `TICK_DIV` clocks. The count changes only on an update pulse, and it steps by one only while control bit 2 (run) is 1.
- R3: A write to word 2 (load) is stored and reads back at once. The count takes that value at the next update pulse, whether or not run is set. Until then the count keeps its old value.
- R4: An alarm hit sets a sticky raw flag. A hit is an update pulse with run set and count equal to word 1 (alarm). Bit 0 of word 5 shows the raw flag regardless of the enable and mask bits.
- R5: `irq` equals raw AND control bit 0 (enable) AND NOT control bit 1 (mask). Bit 0 of word 4 reads the same value.
- R6: A read of word 6 clears the raw flag and returns zero. If an alarm hit falls in the same cycle, the flag stays set.
- R7: When control bit 3 (wrap) is 1, a hit sends the count to zero on that update pulse. When wrap is 0, the count runs on and rolls over from all ones to zero.
- R8: Word 7 reads the `VERSION` parameter. Writes to words 0, 4, 5, 6 and 7 change nothing, and control keeps only bits 3:0 of the written data.
- R9: Read data for the word at `addr` (byte offset divided by four) is valid in the cycle after `rd_en`, and `rdata` holds its value while `rd_en` is low.
- R10: A load pending at an update pulse takes priority over the step by one and over the wrap to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe for the word at `addr` |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 3 | Register word index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level alarm interrupt |

## Verification
The count is exercised with run on and off, with loads issued while stopped and while running, and with a load just below all ones. Together these separate a true step from a held value, a deferred load from an immediate one, and the natural rollover from the wrap-on-hit path. The alarm path walks the enable and mask settings over one held raw flag, so that gating faults show apart from flag faults. An acknowledge read is then placed exactly on a hit cycle to expose the wrong priority between hit and acknowledge. Writes aimed at read-only words and oversized control data check that nothing leaks into state.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int NUM_REGS = 8;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int CTRL_W   = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_NOW      = 3'd0,
    REG_ALARM    = 3'd1,
    REG_LOAD     = 3'd2,
    REG_CTRL     = 3'd3,
    REG_IRQ_STAT = 3'd4,
    REG_RAW_STAT = 3'd5,
    REG_ACK      = 3'd6,
    REG_VER      = 3'd7
  } reg_idx_e;

  // bit 3 wrap, bit 2 run, bit 1 mask, bit 0 enable
  typedef struct packed {
    logic wrap;
    logic run;
    logic mask;
    logic ie;
  } ctrl_t;

  function automatic logic irq_level(input logic raw, input logic ie, input logic mask);
    return raw & ie & ~mask;
  endfunction
endpackage

// File: rtl/sat_prescaler.sv
module sat_prescaler #(
  parameter int TICK_DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + PW'(1);
  end

  assign tick = (pre_q == LAST);

  // R2: update pulses never come back to back (TICK_DIV >= 2)
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          wrap,
  input  logic          hit,
  input  logic          ld_wr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] count,
  output logic [DW-1:0] load_q
);
  logic pend_q;

  function automatic logic [DW-1:0] next_count(
    input logic [DW-1:0] cur, input logic [DW-1:0] ld,
    input logic pend, input logic go, input logic to_zero);
    if (pend)    return ld;
    if (!go)     return cur;
    if (to_zero) return '0;
    return cur + DW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      load_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick) count <= next_count(count, load_q, pend_q, run, wrap & hit);
      if (ld_wr) load_q <= ld_data;
      if (ld_wr)     pend_q <= 1'b1;
      else if (tick) pend_q <= 1'b0;
    end
  end

  // R2: without an update pulse the count is frozen
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R2: plain step while running
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !pend_q && !(wrap && hit)) |=> count == $past(count) + DW'(1));
  // R3, R10: a pending load wins at the pulse
  assert_load_apply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |=> count == $past(load_q));
  // R7: wrap-on-hit returns to zero
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && wrap && !pend_q) |=> count == '0);
endmodule

// File: rtl/sat_alarm.sv
module sat_alarm import sat_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          ie,
  input  logic          mask,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] alarm,
  input  logic          ack_rd,
  output logic          hit,
  output logic          raw,
  output logic          irq
);
  assign hit = tick & run & (count == alarm);

  always_ff @(posedge clk) begin
    if (!rst_n)      raw <= 1'b0;
    else if (hit)    raw <= 1'b1;
    else if (ack_rd) raw <= 1'b0;
  end

  assign irq = irq_level(raw, ie, mask);

  // R4: the raw flag is sticky until acknowledged
  assert_raw_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !ack_rd) |=> raw);
  // R6: acknowledge clears when no hit competes
  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !hit) |=> !raw);
  // R6: a hit wins over a same-cycle acknowledge
  assert_hit_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw);
  // R5: a masked block keeps the line quiet
  assert_mask_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);
endmodule

// File: rtl/sat_regfile.sv
module sat_regfile import sat_pkg::*; #(
  parameter int              DW      = 32,
  parameter logic [DW-1:0]   VERSION = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     count,
  input  logic [DW-1:0]     load_q,
  input  logic              raw,
  input  logic              irq,
  output logic [DW-1:0]     alarm_q,
  output ctrl_t             ctrl_q,
  output logic              ld_wr,
  output logic              ack_rd,
  output logic [DW-1:0]     rdata
);
  reg_idx_e    idx;
  logic [DW-1:0] rd_mux;

  assign idx    = reg_idx_e'(addr);
  assign ld_wr  = wr_en && (idx == REG_LOAD);
  assign ack_rd = rd_en && (idx == REG_ACK);

  always_comb begin
    case (idx)
      REG_NOW:      rd_mux = count;
      REG_ALARM:    rd_mux = alarm_q;
      REG_LOAD:     rd_mux = load_q;
      REG_CTRL:     rd_mux = DW'(ctrl_q);
      REG_IRQ_STAT: rd_mux = DW'(irq);
      REG_RAW_STAT: rd_mux = DW'(raw);
      REG_VER:      rd_mux = VERSION;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
      ctrl_q  <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en && idx == REG_ALARM) alarm_q <= wdata;
      if (wr_en && idx == REG_CTRL)  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R9: read data only moves on a read strobe
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R8: version word
  assert_ver_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == REG_VER) |=> rdata == VERSION);
  // R6: acknowledge read returns zero
  assert_ack_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |=> rdata == '0);
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer import sat_pkg::*; #(
  parameter int                DATA_W   = 32,
  parameter int                TICK_DIV = 100_000_000,
  parameter logic [DATA_W-1:0] VERSION  = DATA_W'(32'h0001_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic              tick;
  logic              hit;
  logic              raw_flag;
  logic              ld_wr;
  logic              ack_rd;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] alarm_q;
  ctrl_t             ctrl_q;

  sat_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  sat_counter #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q.run), .wrap(ctrl_q.wrap),
    .hit(hit), .ld_wr(ld_wr), .ld_data(wdata), .count(count_q), .load_q(load_q));

  sat_alarm #(.DW(DATA_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_q.run), .ie(ctrl_q.ie),
    .mask(ctrl_q.mask), .count(count_q), .alarm(alarm_q), .ack_rd(ack_rd),
    .hit(hit), .raw(raw_flag), .irq(irq));

  sat_regfile #(.DW(DATA_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .count(count_q), .load_q(load_q), .raw(raw_flag), .irq(irq),
    .alarm_q(alarm_q), .ctrl_q(ctrl_q), .ld_wr(ld_wr), .ack_rd(ack_rd),
    .rdata(rdata));

  // R1: out of reset the line is quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/tb_sec_alarm_timer.sv
module tb_sec_alarm_timer;
  localparam int          DIV = 8;
  localparam logic [31:0] VER = 32'h0001_0203;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2 clk = ~clk;

  sec_alarm_timer #(.DATA_W(32), .TICK_DIV(DIV), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t  sbq[$];
  string cur_tag = "R1";

  // bench reference state, written from the requirements
  int unsigned m_pre;
  logic [31:0] m_cnt, m_alarm, m_load;
  logic        m_pend, m_raw;
  logic [3:0]  m_ctrl;

  function automatic logic m_irq();
    return m_raw && m_ctrl[0] && !m_ctrl[1];
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic tk, hit;
    exp_t e;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_alarm = 0; m_load = 0;
      m_pend = 0; m_raw = 0; m_ctrl = 0;
    end else begin
      tk = (m_pre == DIV - 1);
      if (rd_en) begin
        case (addr)
          3'd0: e.v = m_cnt;
          3'd1: e.v = m_alarm;
          3'd2: e.v = m_load;
          3'd3: e.v = {28'b0, m_ctrl};
          3'd4: e.v = {31'b0, m_irq()};
          3'd5: e.v = {31'b0, m_raw};
          3'd6: e.v = 32'b0;
          default: e.v = VER;
        endcase
        e.tag = cur_tag;
        sbq.push_back(e);
      end
      hit = tk && m_ctrl[2] && (m_cnt == m_alarm);
      if (tk) begin
        if (m_pend)         m_cnt = m_load;
        else if (m_ctrl[2]) m_cnt = (m_ctrl[3] && hit) ? 32'd0 : m_cnt + 32'd1;
      end
      if (hit) m_raw = 1'b1;
      else if (rd_en && addr == 3'd6) m_raw = 1'b0;
      if (tk) m_pend = 1'b0;
      if (wr_en) begin
        case (addr)
          3'd1: m_alarm = wdata;
          3'd2: begin m_load = wdata; m_pend = 1'b1; end
          3'd3: m_ctrl = wdata[3:0];
          default: ;
        endcase
      end
      m_pre = tk ? 0 : m_pre + 1;
    end
  end

  // scoreboard monitor: read results and the interrupt line
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      check(rdata, e.v, e.tag);
    end
    if (rst_n) check({31'b0, irq}, {31'b0, m_irq()}, "R5 irq");
  end

  task automatic rd(input logic [2:0] a, input string t);
    @(negedge clk); cur_tag = t; rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sync_after_tick();
    do @(negedge clk); while (m_pre != 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 6; i++) rd(3'(i), "R1 reset");
    rd(3'd7, "R8 version");
    check({31'b0, irq}, 32'd0, "R1 irq");

    // R2 counting with run on, then held with run off
    wr(3'd3, 32'h4);
    repeat (5 * DIV) @(negedge clk);
    rd(3'd0, "R2 run");
    wr(3'd3, 32'h0);
    rd(3'd0, "R2 stop a");
    repeat (3 * DIV) @(negedge clk);
    rd(3'd0, "R2 stop b");

    // R3 deferred load while stopped, R7 natural rollover
    sync_after_tick();
    wr(3'd2, 32'hFFFF_FFFD);
    rd(3'd2, "R3 readback");
    rd(3'd0, "R3 deferred");
    repeat (DIV) @(negedge clk);
    rd(3'd0, "R3 applied");
    wr(3'd3, 32'h4);
    repeat (4 * DIV) @(negedge clk);
    rd(3'd0, "R7 rollover");

    // R10 load beats step while running
    sync_after_tick();
    wr(3'd2, 32'h50);
    rd(3'd0, "R10 before");
    repeat (DIV) @(negedge clk);
    rd(3'd0, "R10 after");

    // R4 R5 alarm flag and gating
    wr(3'd2, 32'd100);
    wr(3'd1, 32'd103);
    repeat (7 * DIV) @(negedge clk);
    rd(3'd5, "R4 raw");
    rd(3'd4, "R5 disabled");
    wr(3'd3, 32'h5);
    rd(3'd4, "R5 enabled");
    wr(3'd3, 32'h7);
    rd(3'd4, "R5 masked");
    rd(3'd5, "R4 raw masked");
    wr(3'd3, 32'h5);
    rd(3'd6, "R6 ack data");
    rd(3'd5, "R6 cleared");

    // R7 wrap on hit
    wr(3'd1, 32'd2);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'hD);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV - 2) @(negedge clk);
      rd(3'd0, "R7 wrap");
    end

    // R6 hit and acknowledge in the same cycle
    do @(negedge clk); while (!(m_pre == DIV - 1 && m_cnt == m_alarm));
    cur_tag = "R6 same"; rd_en = 1'b1; addr = 3'd6;
    @(negedge clk); rd_en = 1'b0;
    rd(3'd5, "R6 hit wins");
    check({31'b0, m_raw}, 32'd1, "R6 hit wins ref");

    // R8 read-only words and control width
    wr(3'd3, 32'h0);
    wr(3'd0, 32'hDEAD_BEEF);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1234_5678);
    rd(3'd0, "R8 count kept");
    rd(3'd5, "R8 raw kept");
    rd(3'd7, "R8 version kept");
    wr(3'd3, 32'hFFFF_FFF8);
    rd(3'd3, "R8 ctrl width");
    rd(3'd1, "R9 alarm readback");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule